// File: doc/BRIEF.md
# Banked Clock Divider with Glitch-Free Gating

This block takes one of two reference clocks and distributes it to four banks of four outputs each. Every bank has its own divide control and its own enable. The divide control selects either the reference frequency or half of it. The enable stops a bank with its outputs parked low, and starts it again, without ever producing a shortened pulse. Both per-bank controls are brought into the selected clock domain on its falling edge. As a result, a bank's output gate and its divide mux only change while the reference clock is low.

An active-low master reset clears every divider and every synchronizer stage. While it is asserted, it also drops the whole output-enable vector, so the pads around the block see every output in high impedance. The block is a clock-tree leaf: the surrounding logic drives the selects and enables, and the outputs go straight to clock loads.

Top module: `clk_bank_fanout`

## Requirements
- R1: With `ref_pick` = 0 every active bank is timed by `ref_a`; with `ref_pick` = 1 it is timed by `ref_b`.
- R2: A bank whose divide control is 1 (undivided) and whose enable is active outputs a copy of the selected clock: high in its high phase, low in its low phase.
- R3: A bank whose divide control is 0 (halved) and whose enable is active toggles its output on every rising edge of the selected clock, which gives half the frequency at 50% duty.
- R4: A bank whose effective enable is 0 holds all four of its outputs low, and its output-enable bits stay 1.
- R5: While `mr_n` is 0, all 16 bits of `out_oe` are 0 and all outputs are 0, whatever the selects and enables are.
- R6: Enable and divide-control changes take effect at the second falling edge of the selected clock after they are sampled. A halved bank's divider holds at 0 while the bank is off or undivided, so its first rising output edge comes from the first rising clock edge after it starts.
- R7: No output high or low pulse is shorter than half a period of the selected clock, even when enables and divide controls change at arbitrary times.
- R8: Bank k drives `clk_out[4k+3:4k]`, and those four bits are always equal.
- R9: Switching a running bank between halved and undivided changes its output only at a falling edge of the selected clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_a | input | 1 | First reference clock |
| ref_b | input | 1 | Second reference clock |
| ref_pick | input | 1 | 1 selects `ref_b`, 0 selects `ref_a` |
| mr_n | input | 1 | Active-low master reset and output disable |
| div_full | input | 4 | Per bank: 1 passes the clock undivided, 0 halves it |
| bank_en | input | 4 | Per bank: 1 runs the bank, 0 parks its outputs low |
| clk_out | output | 16 | Bank outputs, four per bank, bank 0 in the low nibble |
| out_oe | output | 16 | Per output enable; 0 means high impedance |

## Verification
A wrong synchronizer state shows up one clock phase early or late. A bank then starts or stops half or a whole reference period away from the point the bench predicts, and the next mid-phase sample catches it. A divider that is not parked, or that has a stale phase, produces a halved output in antiphase. This appears within one reference period after enable or after a select change. A gate or mux that changes while the clock is high shows up as a pulse narrower than half a reference period. A pulse-width monitor reports it on the very edge that ends the pulse.

// File: rtl/fanout_pkg.sv
`timescale 1ns/1ps
package fanout_pkg;
    // Per-bank control pair as seen by one slice.
    typedef struct packed {
        logic en;    // bank runs when 1
        logic full;  // 1 = undivided, 0 = halved
    } bank_ctl_t;
endpackage

// File: rtl/ref_clk_select.sv
`timescale 1ns/1ps
module ref_clk_select (
    input  logic clk_a,
    input  logic clk_b,
    input  logic pick_b,
    output logic clk_o
);
    // Static select: expected to change only while the block is held in reset.
    assign clk_o = pick_b ? clk_b : clk_a;
endmodule

// File: rtl/bank_gate.sv
`timescale 1ns/1ps
module bank_gate
    import fanout_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bank_ctl_t ctl_in,
    output logic      bank_out
);
    localparam int TOP = SYNC_STAGES - 1;

    // Falling-edge synchronizer state.
    typedef struct packed {
        logic [SYNC_STAGES-1:0] en_pipe;
        logic [SYNC_STAGES-1:0] full_pipe;
    } sync_state_t;

    // Rising-edge divider state.
    typedef struct packed {
        logic phase;
    } div_state_t;

    sync_state_t s_d, s_q;
    div_state_t  v_d, v_q;
    logic        en_on;
    logic        full_on;

    assign en_on   = s_q.en_pipe[TOP];
    assign full_on = s_q.full_pipe[TOP];

    always_comb begin
        s_d           = s_q;
        s_d.en_pipe   = {s_q.en_pipe[SYNC_STAGES-2:0], ctl_in.en};
        s_d.full_pipe = {s_q.full_pipe[SYNC_STAGES-2:0], ctl_in.full};
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // The divider runs only while halving; otherwise it is parked at 0,
    // so a restart always begins with a full low phase.
    always_comb begin
        v_d = v_q;
        if (en_on && !full_on) v_d.phase = !v_q.phase;
        else                   v_d.phase = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    // Gate and mux inputs move only on falling edges, with the clock low.
    assign bank_out = en_on & (full_on ? clk : v_q.phase);

    AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_on && !full_on) |=> (v_q.phase != $past(v_q.phase)))
        else $error("halved bank did not toggle"); // R3

    AST_DIV_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_on && !full_on) |=> !v_q.phase)
        else $error("divider not parked"); // R6

    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_on |-> !bank_out)
        else $error("disabled bank not low"); // R4

    AST_FULL_FOLLOWS: assert property (@(negedge clk) disable iff (!rst_n)
        (en_on && full_on) |-> bank_out)
        else $error("undivided bank missed high phase"); // R2
endmodule

// File: rtl/clk_bank_fanout.sv
`timescale 1ns/1ps
module clk_bank_fanout
    import fanout_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK_WIDTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              ref_a,
    input  logic                              ref_b,
    input  logic                              ref_pick,
    input  logic                              mr_n,
    input  logic [NUM_BANKS-1:0]              div_full,
    input  logic [NUM_BANKS-1:0]              bank_en,
    output logic [NUM_BANKS*BANK_WIDTH-1:0]   clk_out,
    output logic [NUM_BANKS*BANK_WIDTH-1:0]   out_oe
);
    localparam int NUM_OUT = NUM_BANKS * BANK_WIDTH;

    logic                 clk_sel;
    logic [NUM_BANKS-1:0] bank_lvl;

    ref_clk_select u_sel (
        .clk_a  (ref_a),
        .clk_b  (ref_b),
        .pick_b (ref_pick),
        .clk_o  (clk_sel)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        bank_ctl_t ctl;
        assign ctl.en   = bank_en[k];
        assign ctl.full = div_full[k];

        bank_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk      (clk_sel),
            .rst_n    (mr_n),
            .ctl_in   (ctl),
            .bank_out (bank_lvl[k])
        );

        assign clk_out[k*BANK_WIDTH +: BANK_WIDTH] = {BANK_WIDTH{bank_lvl[k]}};
    end

    assign out_oe = {NUM_OUT{mr_n}};

    always @(posedge clk_sel) begin
        if (!mr_n) begin
            AST_RESET_QUIET: assert (clk_out == '0 && out_oe == '0)
                else $error("outputs active during reset"); // R5
        end
    end
endmodule

// File: tb/clk_bank_fanout_test.sv
`timescale 1ns/1ps
module clk_bank_fanout_test;
    localparam real CLK_PERIOD = 10.0;
    localparam real B_PERIOD   = 14.0;

    logic        ref_a = 1'b0;
    logic        ref_b = 1'b0;
    logic        ref_pick;
    logic        mr_n;
    logic [3:0]  div_full;
    logic [3:0]  bank_en;
    logic [15:0] clk_out;
    logic [15:0] out_oe;
    string       cur_req = "R5";

    int checks = 0, fails = 0;
    int c_checks = 0, c_fails = 0;
    int p_checks = 0, p_fails = 0;

    clk_bank_fanout uut (
        .ref_a(ref_a), .ref_b(ref_b), .ref_pick(ref_pick), .mr_n(mr_n),
        .div_full(div_full), .bank_en(bank_en),
        .clk_out(clk_out), .out_oe(out_oe)
    );

    initial forever #(CLK_PERIOD/2) ref_a = ~ref_a;
    initial begin #2; forever #(B_PERIOD/2) ref_b = ~ref_b; end

    wire selclk = ref_pick ? ref_b : ref_a;

    // Behavioural reference: start/stop after two falling edges, halved banks
    // alternate on rising edges and rest at 0 otherwise.
    logic [3:0] q_en [$];
    logic [3:0] q_full [$];
    logic [3:0] m_en = '0, m_full = '0, m_phase = '0;

    always @(negedge selclk or negedge mr_n) begin
        if (!mr_n) begin
            q_en = {4'b0, 4'b0};
            q_full = {4'b0, 4'b0};
            m_en = '0; m_full = '0;
        end else begin
            q_en.push_back(bank_en);
            q_full.push_back(div_full);
            m_en = q_en.pop_front();
            m_full = q_full.pop_front();
            while (q_en.size() > 1) begin m_en = q_en.pop_front(); m_full = q_full.pop_front(); end
        end
    end

    always @(posedge selclk or negedge mr_n) begin
        if (!mr_n) m_phase = '0;
        else begin
            for (int b = 0; b < 4; b++)
                m_phase[b] = (m_en[b] && !m_full[b]) ? !m_phase[b] : 1'b0;
        end
    end

    // Mid-phase comparison against the model on every clock edge.
    always @(selclk) begin
        logic lvl;
        logic [3:0] exp_n;
        lvl = selclk;
        #2;
        for (int b = 0; b < 4; b++) begin
            exp_n = {4{m_en[b] && (m_full[b] ? lvl : m_phase[b])}};
            c_checks++;
            if (clk_out[4*b +: 4] !== exp_n) begin
                c_fails++;
                $display("FAIL %s/R8 bank %0d at %0t: got %b expected %b",
                         cur_req, b, $time, clk_out[4*b +: 4], exp_n);
            end
        end
        c_checks++;
        if (out_oe !== {16{mr_n}}) begin
            c_fails++;
            $display("FAIL R5 oe at %0t: got %h expected %h", $time, out_oe, {16{mr_n}});
        end
    end

    // R7 pulse-width monitor.
    logic [3:0] seen = '0, armed = '0;
    realtime    last [4];
    always @(clk_out or mr_n) begin
        real half;
        half = ref_pick ? B_PERIOD/2 : CLK_PERIOD/2;
        for (int b = 0; b < 4; b++) begin
            if (!mr_n) armed[b] = 1'b0;
            else if (clk_out[4*b] !== seen[b]) begin
                if (armed[b]) begin
                    p_checks++;
                    if ($realtime - last[b] < half - 0.01) begin
                        p_fails++;
                        $display("FAIL R7 bank %0d pulse at %0t: got %0.2f expected >= %0.2f",
                                 b, $time, $realtime - last[b], half);
                    end
                end
                armed[b] = 1'b1;
                last[b] = $realtime;
            end
            seen[b] = clk_out[4*b];
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: got %h expected %h", req, $time, act, exp_v);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge selclk);
        #1;
    endtask

    task automatic report;
        int total, bad;
        total = checks + c_checks + p_checks;
        bad   = fails + c_fails + p_fails;
        $display("%0d/%0d checks passed", total - bad, total);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        ref_pick = 1'b0; mr_n = 1'b0; bank_en = 4'hF; div_full = 4'b0101;
        step(3);
        check(clk_out == 16'h0 && out_oe == 16'h0, "R5", {clk_out[7:0], out_oe[7:0]}, 16'h0);

        cur_req = "R6"; mr_n = 1'b1; step(6);
        cur_req = "R3"; step(40);
        cur_req = "R2"; div_full = 4'b1111; step(20);
        cur_req = "R9"; div_full = 4'b0011; step(20);
        div_full = 4'b1100; @(negedge selclk); #1; step(20);

        cur_req = "R4"; bank_en = 4'b1011; step(10);
        check(out_oe == 16'hFFFF, "R4", out_oe, 16'hFFFF);
        @(negedge selclk); #2;
        check(clk_out[11:8] == 4'h0, "R4", {12'h0, clk_out[11:8]}, 16'h0);
        check(clk_out[15:12] == {4{clk_out[12]}}, "R8", {12'h0, clk_out[15:12]}, {12'h0, {4{clk_out[12]}}});

        cur_req = "R7";
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 2) @(negedge selclk); else @(posedge selclk);
            #1;
            if ($urandom % 3 == 0) div_full = 4'($urandom);
            else                   bank_en  = 4'($urandom);
            step(int'($urandom % 4));
        end

        cur_req = "R5";
        @(posedge selclk); #1; bank_en = 4'hF; div_full = 4'hF;
        step(4); #2;
        mr_n = 1'b0; #1;
        check(clk_out == 16'h0, "R5", clk_out, 16'h0);
        check(out_oe == 16'h0, "R5", out_oe, 16'h0);

        ref_pick = 1'b1; div_full = 4'b0110; bank_en = 4'hF;
        step(3);
        cur_req = "R1"; mr_n = 1'b1; step(60);
        for (int i = 0; i < 3; i++) begin
            @(posedge ref_b); #2;
            check(clk_out[7:4] == 4'hF, "R1", {12'h0, clk_out[7:4]}, 16'h000F);
            @(negedge ref_b); #2;
            check(clk_out[7:4] == 4'h0, "R1", {12'h0, clk_out[7:4]}, 16'h0);
        end
        cur_req = "R3"; step(20);

        report();
        $finish;
    end
endmodule